// File: doc/BRIEF.md
# Bus Initiator Request Sequencer

This block is the master-side sequencer between an internal processor-side transaction port and a 32-bit multiplexed address/data bus. It accepts a transaction and chooses when to raise the bus request. A write first collects all of its data beats from the internal side, and only then asks for the bus. A read asks for the bus on the cycle after it is accepted. A read is accepted only when its address decodes to the external space.

Once the bus is granted and is seen idle, the block drives one address phase carrying the 32-bit address and a 4-bit command. It then runs the data phases back to back, up to eight 32-bit beats (32 bytes). It never inserts an initiator wait state. The burst can be cut short by a target abort or a master abort. In that case the block reports an error status on its completion pulse.

Top module: `busmst_seq`

## Requirements
- R1: A write (req_write=1, or kind 3) is accepted without a bus request. bus_req stays 0 while its data beats are pushed, and rises on the cycle after the edge that takes the push marked wr_last.
- R2: A read is acknowledged (req_ack=1) in the idle state only if its address decodes as external. For kinds 0 (memory) and 1 (I/O) that means req_addr >= EXT_BASE. When acknowledged, bus_req is 1 on the cycle after the accepting edge. A memory or I/O read below EXT_BASE gets no acknowledge and raises no request while it is held.
- R3: Kinds 2 (configuration), 3 (special cycle) and 4 (interrupt acknowledge) are treated as external at any address.
- R4: The address phase (frame_out=1, irdy_out=0, ad_oe=1, ad_out=address, cbe_out=command) follows only a clock edge at which bus_gnt=1, frame_in=0 and irdy_in=0. Without the grant, or while the bus is busy, the request stays raised and no address phase starts.
- R5: The command codes are 0000 for interrupt acknowledge, 0001 for special cycle, 0010/0011 for I/O read/write, 0110/0111 for memory read/write, and 1010/1011 for configuration read/write. Kind 3 always acts as a write and kind 4 always acts as a read, whatever req_write says.
- R6: From the first data phase until the last beat completes, irdy_out is 1 on every cycle. A beat completes on a cycle where irdy_out=1 and trdy_in=1. cbe_out carries the beat's byte enables. These are the pushed enables for a write, and req_be for every beat of a read.
- R7: A write carries exactly as many beats as were pushed (1 to 8), in push order, on ad_out with ad_oe=1. A read carries req_len+1 beats. For each completed read beat, rd_valid=1 and rd_data equals ad_in.
- R8: frame_out is 0 during the last data phase. The cycle after the last beat completes, done is 1 for exactly one cycle with done_err=0.
- R9: If tabort_in or mabort_in is asserted during a data phase, the transfer ends. On the next cycle done=1 and done_err=1, with frame_out=0 and irdy_out=0.
- R10: After reset, bus_req, frame_out, irdy_out, ad_oe, done and req_ack are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal transaction presented |
| req_addr | input | 32 | Transaction address |
| req_kind | input | 3 | 0 memory, 1 I/O, 2 configuration, 3 special cycle, 4 interrupt acknowledge |
| req_write | input | 1 | 1 for write (memory, I/O, configuration) |
| req_len | input | 3 | Read beats minus one |
| req_be | input | 4 | Byte enables used on every read beat |
| req_ack | output | 1 | Transaction taken this cycle |
| wr_push | input | 1 | Write data beat offered |
| wr_data | input | 32 | Write data beat |
| wr_be | input | 4 | Byte enables of the write beat |
| wr_last | input | 1 | Marks the final write beat |
| rd_valid | output | 1 | Read beat completed this cycle |
| rd_data | output | 32 | Read beat data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was an abort |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| frame_in | input | 1 | Observed frame (bus busy) |
| irdy_in | input | 1 | Observed initiator ready |
| trdy_in | input | 1 | Target ready |
| tabort_in | input | 1 | Target abort |
| mabort_in | input | 1 | Master abort (no target claimed) |
| ad_in | input | 32 | Address/data bus input |
| ad_out | output | 32 | Address/data bus output |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_out | output | 4 | Command or byte enables |
| frame_out | output | 1 | Frame driven by this initiator |
| irdy_out | output | 1 | Initiator ready |

## Verification
The hardest situation to reach is a pending request that must hold back: the grant is missing, or the grant is present while another master still owns the bus. The stimulus first launches a read with the grant withdrawn. It then restores the grant while a bench-side model keeps the observed frame busy, and checks across several cycles that the request stays up and no address phase appears. Only then does it free the bus. The aborted transfers are reached by arming the target model to raise target abort or master abort on the first data phase of a read and of a write.

// File: rtl/busmst_pkg.sv
package busmst_pkg;

   localparam logic [2:0] KIND_MEM  = 3'd0;
   localparam logic [2:0] KIND_IO   = 3'd1;
   localparam logic [2:0] KIND_CFG  = 3'd2;
   localparam logic [2:0] KIND_SPEC = 3'd3;
   localparam logic [2:0] KIND_IACK = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_FILL = 3'd1,
      ST_REQ  = 3'd2,
      ST_ADDR = 3'd3,
      ST_DATA = 3'd4
   } seq_state_e;

endpackage

// File: rtl/busmst_cmd_enc.sv
module busmst_cmd_enc
   import busmst_pkg::*;
(
   input  logic [2:0] kind,
   input  logic       is_wr,
   output logic [3:0] cmd
);
   always_comb begin
      case (kind)
         KIND_IO:   cmd = is_wr ? 4'b0011 : 4'b0010;
         KIND_CFG:  cmd = is_wr ? 4'b1011 : 4'b1010;
         KIND_SPEC: cmd = 4'b0001;
         KIND_IACK: cmd = 4'b0000;
         default:   cmd = is_wr ? 4'b0111 : 4'b0110;
      endcase
   end
endmodule

// File: rtl/busmst_wbuf.sv
module busmst_wbuf #(
   parameter int DATA_W = 32,
   parameter int BE_W   = DATA_W / 8,
   parameter int DEPTH  = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic [BE_W-1:0]   bein,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] dout,
   output logic [BE_W-1:0]   beout,
   output logic [CNT_W-1:0]  cnt
);
   logic [DATA_W-1:0] slot_d  [DEPTH];
   logic [BE_W-1:0]   slot_be [DEPTH];
   logic              full;

   assign full = (cnt == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (push && !full)
         cnt <= cnt + CNT_W'(1);
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && !full && (cnt == CNT_W'(gi))) begin
            slot_d[gi]  <= din;
            slot_be[gi] <= bein;
         end
      end
   end

   assign dout  = slot_d[rd_idx];
   assign beout = slot_be[rd_idx];

   p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/busmst_beat_ctr.sv
module busmst_beat_ctr #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic [IDX_W-1:0] last_idx,
   output logic [IDX_W-1:0] idx,
   output logic             is_last
);
   always_ff @(posedge clk) begin
      if (!rst_n || load)
         idx <= '0;
      else if (adv && !is_last)
         idx <= idx + IDX_W'(1);
   end

   assign is_last = (idx == last_idx);

   p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !is_last && !load) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/busmst_seq.sv
module busmst_seq
   import busmst_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          DATA_W    = 32,
   parameter int          MAX_BEATS = 8,
   parameter logic [31:0] EXT_BASE  = 32'h8000_0000,
   localparam int BE_W  = DATA_W / 8,
   localparam int IDX_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
   localparam int CNT_W = $clog2(MAX_BEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_kind,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_len,
   input  logic [BE_W-1:0]   req_be,
   output logic              req_ack,
   input  logic              wr_push,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BE_W-1:0]   wr_be,
   input  logic              wr_last,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              done_err,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              frame_in,
   input  logic              irdy_in,
   input  logic              trdy_in,
   input  logic              tabort_in,
   input  logic              mabort_in,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [BE_W-1:0]   cbe_out,
   output logic              frame_out,
   output logic              irdy_out
);
   if (ADDR_W != 32) begin : g_bad_addr
      $error("busmst_seq: ADDR_W must be 32");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("busmst_seq: DATA_W must be 32");
   end
   if (MAX_BEATS < 1 || MAX_BEATS * BE_W > 32) begin : g_bad_beats
      $error("busmst_seq: burst must be 1 to 32 bytes");
   end

   seq_state_e           st;
   logic [ADDR_W-1:0]    l_addr;
   logic [2:0]           l_kind;
   logic                 l_wr;
   logic [IDX_W-1:0]     l_len;
   logic [BE_W-1:0]      l_be;
   logic                 ext_hit;
   logic                 eff_wr;
   logic                 accept;
   logic                 bus_free;
   logic                 abort_now;
   logic                 beat_done;
   logic [3:0]           cmd;
   logic [DATA_W-1:0]    buf_d;
   logic [BE_W-1:0]      buf_be;
   logic [CNT_W-1:0]     buf_cnt;
   logic [CNT_W-1:0]     buf_cnt_m1;
   logic [IDX_W-1:0]     last_idx;
   logic [IDX_W-1:0]     beat_idx;
   logic                 beat_last;

   // Memory and I/O decode against the window; other kinds always go out.
   always_comb begin
      case (req_kind)
         KIND_CFG, KIND_SPEC, KIND_IACK: ext_hit = 1'b1;
         default:                        ext_hit = (req_addr >= EXT_BASE);
      endcase
   end

   always_comb begin
      case (req_kind)
         KIND_SPEC: eff_wr = 1'b1;
         KIND_IACK: eff_wr = 1'b0;
         default:   eff_wr = req_write;
      endcase
   end

   assign accept    = (st == ST_IDLE) && req_valid && ext_hit;
   assign bus_free  = bus_gnt && !frame_in && !irdy_in;
   assign abort_now = tabort_in || mabort_in;
   assign beat_done = (st == ST_DATA) && trdy_in && !abort_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         l_addr   <= '0;
         l_kind   <= KIND_MEM;
         l_wr     <= 1'b0;
         l_len    <= '0;
         l_be     <= '0;
         done     <= 1'b0;
         done_err <= 1'b0;
      end else begin
         done     <= 1'b0;
         done_err <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  l_addr <= req_addr;
                  l_kind <= req_kind;
                  l_wr   <= eff_wr;
                  l_len  <= req_len;
                  l_be   <= req_be;
                  st     <= eff_wr ? ST_FILL : ST_REQ;
               end
            end
            ST_FILL: begin
               if (wr_push && wr_last) st <= ST_REQ;
            end
            ST_REQ: begin
               if (bus_free) st <= ST_ADDR;
            end
            ST_ADDR: st <= ST_DATA;
            ST_DATA: begin
               if (abort_now) begin
                  st       <= ST_IDLE;
                  done     <= 1'b1;
                  done_err <= 1'b1;
               end else if (trdy_in && beat_last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   busmst_cmd_enc u_cmd (
      .kind  (l_kind),
      .is_wr (l_wr),
      .cmd   (cmd)
   );

   busmst_wbuf #(
      .DATA_W (DATA_W),
      .BE_W   (BE_W),
      .DEPTH  (MAX_BEATS)
   ) u_wbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .push   (wr_push && (st == ST_FILL)),
      .din    (wr_data),
      .bein   (wr_be),
      .rd_idx (beat_idx),
      .dout   (buf_d),
      .beout  (buf_be),
      .cnt    (buf_cnt)
   );

   assign buf_cnt_m1 = buf_cnt - CNT_W'(1);
   assign last_idx   = l_wr ? buf_cnt_m1[IDX_W-1:0] : l_len;

   busmst_beat_ctr #(
      .IDX_W (IDX_W)
   ) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (st == ST_ADDR),
      .adv      (beat_done),
      .last_idx (last_idx),
      .idx      (beat_idx),
      .is_last  (beat_last)
   );

   always_comb begin
      ad_out  = '0;
      ad_oe   = 1'b0;
      cbe_out = '0;
      if (st == ST_ADDR) begin
         ad_out  = l_addr;
         ad_oe   = 1'b1;
         cbe_out = cmd;
      end else if (st == ST_DATA) begin
         ad_out  = l_wr ? buf_d : '0;
         ad_oe   = l_wr;
         cbe_out = l_wr ? buf_be : l_be;
      end
   end

   assign req_ack   = accept;
   assign bus_req   = (st == ST_REQ);
   assign frame_out = (st == ST_ADDR) || ((st == ST_DATA) && !beat_last);
   assign irdy_out  = (st == ST_DATA);
   assign rd_valid  = beat_done && !l_wr;
   assign rd_data   = ad_in;

   p_wr_req_after_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && l_wr) |-> $past(wr_push && wr_last));

   p_rd_req_prompt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && !l_wr) |-> $past(req_valid));

   p_addr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_out) |-> $past(bus_gnt && !frame_in && !irdy_in));

   p_no_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irdy_out && !trdy_in && !tabort_in && !mabort_in) |=> irdy_out);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> (!frame_out && !irdy_out));
endmodule

// File: tb/tb_busmst_seq.sv
module tb_busmst_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_kind = '0;
   logic        req_write = 1'b0;
   logic [2:0]  req_len = '0;
   logic [3:0]  req_be = '0;
   logic        req_ack;
   logic        wr_push = 1'b0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic        wr_last = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        done, done_err, bus_req;
   logic        bus_gnt = 1'b1;
   logic        other_busy = 1'b0;
   logic        frame_in, irdy_in;
   logic        trdy_in = 1'b0;
   logic        tabort_in = 1'b0;
   logic        mabort_in = 1'b0;
   logic [31:0] ad_in = '0;
   logic [31:0] ad_out;
   logic        ad_oe;
   logic [3:0]  cbe_out;
   logic        frame_out, irdy_out;

   always #5 clk = ~clk;

   assign frame_in = frame_out | other_busy;
   assign irdy_in  = irdy_out;

   busmst_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .req_write(req_write), .req_len(req_len),
      .req_be(req_be), .req_ack(req_ack), .wr_push(wr_push),
      .wr_data(wr_data), .wr_be(wr_be), .wr_last(wr_last),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .done_err(done_err), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .frame_in(frame_in), .irdy_in(irdy_in), .trdy_in(trdy_in),
      .tabort_in(tabort_in), .mabort_in(mabort_in), .ad_in(ad_in),
      .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out),
      .frame_out(frame_out), .irdy_out(irdy_out)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      int          ev;    // 0 address phase, 1 data beat, 2 completion
      logic [31:0] val;
      logic [3:0]  cbe;
      logic        fr;
      logic        err;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   function automatic logic [31:0] rd_word(int n);
      return 32'hC0DE_0000 + 32'(n) * 32'h0001_0011;
   endfunction
   function automatic logic [31:0] wr_word(logic [31:0] seed, int i);
      return seed ^ (32'(i) * 32'h1111_1111);
   endfunction
   function automatic logic [3:0] exp_cmd(logic [2:0] kind, logic wr);
      case (kind)
         3'd1: return wr ? 4'b0011 : 4'b0010;
         3'd2: return wr ? 4'b1011 : 4'b1010;
         3'd3: return 4'b0001;
         3'd4: return 4'b0000;
         default: return wr ? 4'b0111 : 4'b0110;
      endcase
   endfunction

   task automatic push_exp(int ev, logic [31:0] val, logic [3:0] cbe, logic fr, logic err, string tag);
      exp_t e;
      e.ev = ev; e.val = val; e.cbe = cbe; e.fr = fr; e.err = err; e.tag = tag;
      exp_q.push_back(e);
   endtask

   int rd_seq = 0;   // read beats expected so far
   int rcnt   = 0;   // read beats served by the target model
   int arm    = 0;   // 1 target abort, 2 master abort on next data phase
   bit slow   = 0;
   bit tgl    = 0;
   bit hold_prev = 0;

   // target model
   always @(posedge clk) begin
      if (irdy_out && trdy_in && !tabort_in && !mabort_in && !ad_oe) rcnt++;
      if (tabort_in || mabort_in) arm = 0;
      #1;
      tgl       = !tgl;
      tabort_in = irdy_out && (arm == 1);
      mabort_in = irdy_out && (arm == 2);
      trdy_in   = irdy_out && (arm == 0) && (!slow || tgl);
      ad_in     = rd_word(rcnt);
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         exp_t e;
         int ev;
         ev = -1;
         if (hold_prev)
            chk(irdy_out, "R6", "irdy dropped before last beat", 32'(irdy_out), 32'd1);
         hold_prev = irdy_out && !trdy_in && !tabort_in && !mabort_in;
         if (frame_out && !irdy_out) ev = 0;
         else if (irdy_out && trdy_in && !tabort_in && !mabort_in) ev = 1;
         else if (done) ev = 2;
         if (ev >= 0) begin
            if (exp_q.size() == 0) begin
               chk(0, "R7", "unexpected bus event", 32'(ev), 32'hFFFF_FFFF);
            end else begin
               e = exp_q.pop_front();
               chk(e.ev == ev, e.tag, "event kind", 32'(ev), 32'(e.ev));
               if (e.ev == ev) begin
                  case (ev)
                     0: begin
                        chk(ad_out == e.val && ad_oe, e.tag, "address", ad_out, e.val);
                        chk(cbe_out == e.cbe, e.tag, "command", 32'(cbe_out), 32'(e.cbe));
                     end
                     1: begin
                        if (ad_oe)
                           chk(ad_out == e.val && !rd_valid, e.tag, "write beat", ad_out, e.val);
                        else
                           chk(rd_data == e.val && rd_valid, e.tag, "read beat", rd_data, e.val);
                        chk(cbe_out == e.cbe, e.tag, "byte enables", 32'(cbe_out), 32'(e.cbe));
                        chk(frame_out == e.fr, e.tag, "frame in data phase", 32'(frame_out), 32'(e.fr));
                     end
                     default: begin
                        chk(done_err == e.err, e.tag, "completion status", 32'(done_err), 32'(e.err));
                        if (e.err)
                           chk(!frame_out && !irdy_out, "R9", "bus released after abort",
                               {30'd0, frame_out, irdy_out}, 32'd0);
                     end
                  endcase
               end
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic start_req(logic [31:0] a, logic [2:0] k, logic w, logic [2:0] len, logic [3:0] be);
      @(posedge clk); #1;
      req_valid = 1; req_addr = a; req_kind = k; req_write = w; req_len = len; req_be = be;
      @(negedge clk);
      chk(req_ack, "R2", "request acknowledged", 32'(req_ack), 32'd1);
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
      @(posedge clk); #1;
   endtask

   task automatic exp_read(logic [31:0] a, logic [2:0] k, logic [2:0] len, logic [3:0] be, bit ab);
      push_exp(0, a, exp_cmd(k, 1'b0), 1'b1, 1'b0, "R5");
      if (!ab)
         for (int i = 0; i <= int'(len); i++) begin
            push_exp(1, rd_word(rd_seq), be, (i != int'(len)), 1'b0, "R7");
            rd_seq++;
         end
      push_exp(2, '0, '0, 1'b0, ab, ab ? "R9" : "R8");
   endtask

   task automatic do_read(logic [31:0] a, logic [2:0] k, logic w, logic [2:0] len, logic [3:0] be, bit ab);
      exp_read(a, k, len, be, ab);
      start_req(a, k, w, len, be);
      @(negedge clk);
      chk(bus_req, "R2", "read requests at once", 32'(bus_req), 32'd1);
      wait_done();
   endtask

   task automatic do_write(logic [31:0] a, logic [2:0] k, logic w, int n, logic [31:0] seed, bit gaps, bit ab);
      push_exp(0, a, exp_cmd(k, 1'b1), 1'b1, 1'b0, "R5");
      if (!ab)
         for (int i = 0; i < n; i++)
            push_exp(1, wr_word(seed, i), 4'(4'hF ^ i), (i != n - 1), 1'b0, "R7");
      push_exp(2, '0, '0, 1'b0, ab, ab ? "R9" : "R8");
      start_req(a, k, w, 3'd0, 4'h0);
      for (int i = 0; i < n; i++) begin
         wr_push = 1; wr_data = wr_word(seed, i); wr_be = 4'(4'hF ^ i); wr_last = (i == n - 1);
         @(negedge clk);
         chk(!bus_req, "R1", "no request while filling", 32'(bus_req), 32'd0);
         @(posedge clk); #1;
         wr_push = 0; wr_last = 0;
         if (gaps && i != n - 1) begin
            @(negedge clk);
            chk(!bus_req, "R1", "no request in fill gap", 32'(bus_req), 32'd0);
            @(posedge clk); #1;
         end
      end
      @(negedge clk);
      chk(bus_req, "R1", "request after last write beat", 32'(bus_req), 32'd1);
      wait_done();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(!bus_req && !frame_out && !irdy_out, "R10", "bus outputs idle after reset",
          {29'd0, bus_req, frame_out, irdy_out}, 32'd0);
      chk(!ad_oe && !done && !req_ack, "R10", "drive, done, ack idle after reset",
          {29'd0, ad_oe, done, req_ack}, 32'd0);

      // R2 R7 memory read burst of four
      do_read(32'h9000_0040, 3'd0, 1'b0, 3'd3, 4'hF, 0);
      // R1 R7 memory write of eight beats with gaps in the fill
      do_write(32'hA000_0000, 3'd0, 1'b1, 8, 32'h1234_5678, 1, 0);

      // R2 ignored: memory and I/O reads below EXT_BASE
      @(posedge clk); #1;
      req_valid = 1; req_addr = 32'h7FFF_FFFC; req_kind = 3'd0; req_write = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!req_ack && !bus_req, "R2", "low memory read ignored",
             {30'd0, req_ack, bus_req}, 32'd0);
      end
      @(posedge clk); #1;
      req_kind = 3'd1; req_addr = 32'h0000_0100;
      @(negedge clk);
      chk(!req_ack && !bus_req, "R2", "low I/O read ignored", {30'd0, req_ack, bus_req}, 32'd0);
      @(posedge clk); #1;
      req_valid = 0;
      @(negedge clk);
      chk(!bus_req && !frame_out, "R2", "still idle after ignored reads",
          {30'd0, bus_req, frame_out}, 32'd0);

      // R2 boundary: exactly EXT_BASE is external
      do_read(32'h8000_0000, 3'd0, 1'b0, 3'd0, 4'h3, 0);
      // R3 R5 configuration read/write at low addresses, I/O at external ones
      do_read(32'h0000_0010, 3'd2, 1'b0, 3'd0, 4'hF, 0);
      do_write(32'h0000_00FC, 3'd2, 1'b1, 1, 32'hCAFE_0001, 0, 0);
      do_read(32'h8000_1000, 3'd1, 1'b0, 3'd1, 4'h1, 0);
      do_write(32'h8000_1004, 3'd1, 1'b1, 2, 32'h0BAD_F00D, 0, 0);
      // R5 special cycle forced to write, interrupt acknowledge forced to read
      do_write(32'h0000_0000, 3'd3, 1'b0, 1, 32'h5EC1_A100, 0, 0);
      do_read(32'h0000_0000, 3'd4, 1'b1, 3'd0, 4'hF, 0);

      // R6 slow target: irdy held through waits, 32-byte read
      slow = 1;
      do_read(32'hB000_0000, 3'd0, 1'b0, 3'd7, 4'hC, 0);
      slow = 0;

      // R4 request held without grant, then with a busy bus
      exp_read(32'h9100_0000, 3'd0, 3'd1, 4'hF, 0);
      bus_gnt = 0;
      start_req(32'h9100_0000, 3'd0, 1'b0, 3'd1, 4'hF);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(bus_req && !frame_out, "R4", "no address phase without grant",
             {30'd0, bus_req, frame_out}, 32'd2);
      end
      @(posedge clk); #1;
      bus_gnt = 1; other_busy = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(bus_req && !frame_out, "R4", "no address phase on busy bus",
             {30'd0, bus_req, frame_out}, 32'd2);
         @(posedge clk); #1;
      end
      other_busy = 0;
      wait_done();

      // R9 target abort on a read, master abort on a write
      arm = 1;
      do_read(32'h9200_0000, 3'd0, 1'b0, 3'd3, 4'hF, 1);
      arm = 2;
      do_write(32'hC000_0000, 3'd0, 1'b1, 2, 32'h7777_0000, 0, 1);
      // R8 normal completion after aborts
      do_read(32'h9300_0000, 3'd0, 1'b0, 3'd1, 4'hF, 0);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "all expected bus events seen", 32'(exp_q.size()), 32'd0);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule